// File: doc/BRIEF.md
# Pipelined Four-Element Sorter

This block sorts groups of four unsigned values into ascending order as a stream. Every clock cycle the upstream logic may present one group with a qualifying valid bit. The same four values, reordered so that the smallest sits in lane 0 and the largest in lane 3, leave the block a fixed three cycles later. The valid bit leaves with them.

The core is a five-comparator sorting network split over three register stages:
- Stage one orders lanes 0/1 and 2/3.
- Stage two orders lanes 0/2 and 1/3.
- Stage three orders lanes 1/2, and lanes 0 and 3 pass straight through.

A valid bit travels beside the data through every stage. The block never stalls, so a new group can enter on every cycle. Slots without a valid group travel through like any other slot and do not disturb their neighbours. When the output valid bit is low, the data outputs carry no meaning.

Top module: `qsort4_pipe`

## Requirements
- R1: When out_val is 1, out_data satisfies out_data[0] <= out_data[1] <= out_data[2] <= out_data[3]. Lane i is bits [8i+7:8i] at the default width.
- R2: out_val in any cycle equals the in_val sampled three clock edges earlier, provided the reset was low at all three of those edges.
- R3: A valid output group holds exactly the multiset of values of the matching input group. Duplicates are kept: inputs 8,8,8,2 give 2,8,8,8, and four equal inputs give four copies of that value.
- R4: Valid groups that enter on consecutive cycles leave as sorted groups on consecutive cycles, with no gap.
- R5: A synchronous, active-high rst clears the valid bit of every stage. out_val is 0 after any edge at which rst is high. No group that was in flight or held on the inputs during reset ever emerges.
- R6: A slot that enters with in_val=0 leaves three cycles later with out_val=0. The valid groups before and after it still come out correctly sorted.
- R7: Comparison is unsigned. For example, 0xFF sorts above 0x80, 0x7F and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all stage valid bits |
| in_val | input | 1 | Input group valid |
| in_data | input | 4 x DATA_W | Input group, lane i in in_data[i] |
| out_val | output | 1 | Output group valid |
| out_data | output | 4 x DATA_W | Sorted group, smallest value in out_data[0] |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the extremes 0x00, 0x7F, 0x80 and 0xFF can be hit directly, so a signed-versus-unsigned mistake shows up on a single group. The bench feeds fixed groups back to back: already sorted, reversed, duplicated and all-equal. It then runs a random stream in which roughly one slot in four is idle. Each valid group is compared with a software sort delayed by three cycles. Finally the bench asserts reset with valid groups both in flight and held on the inputs, and confirms that none of them reappears.

// File: rtl/qsort_pkg.sv
package qsort_pkg;
   localparam int unsigned LANES      = 4;
   localparam int unsigned NET_STAGES = 3;

   // Lane that a given lane is compared with in a given network stage.
   // Returning the lane itself means it passes through untouched.
   function automatic int unsigned cas_partner(input int unsigned stage,
                                               input int unsigned lane);
      case (stage)
         0:       return lane ^ 1;
         1:       return lane ^ 2;
         default: return (lane == 1) ? 2 : ((lane == 2) ? 1 : lane);
      endcase
   endfunction
endpackage

// File: rtl/qsort_cas.sv
module qsort_cas #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] lo,
   output logic [DATA_W-1:0] hi
);
   logic a_gt_b;

   assign a_gt_b = (a > b);
   assign lo     = a_gt_b ? b : a;
   assign hi     = a_gt_b ? a : b;
endmodule

// File: rtl/qsort_stage.sv
module qsort_stage
   import qsort_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAGE  = 0
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_vld,
   input  logic [LANES-1:0][DATA_W-1:0] in_data,
   output logic                         out_vld,
   output logic [LANES-1:0][DATA_W-1:0] out_data
);
   logic [DATA_W-1:0] swapped [LANES];

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int unsigned PEER = cas_partner(STAGE, ln);
      if (PEER == ln) begin : g_pass
         assign swapped[ln] = in_data[ln];
      end else if (ln < PEER) begin : g_cas
         qsort_cas #(.DATA_W(DATA_W)) u_cas (
            .a  (in_data[ln]),
            .b  (in_data[PEER]),
            .lo (swapped[ln]),
            .hi (swapped[PEER])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (rst) out_vld <= 1'b0;
      else     out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) out_data[i] <= swapped[i];
   end
endmodule

// File: rtl/qsort4_pipe.sv
module qsort4_pipe
   import qsort_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_val,
   input  logic [LANES-1:0][DATA_W-1:0] in_data,
   output logic                         out_val,
   output logic [LANES-1:0][DATA_W-1:0] out_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("qsort4_pipe: DATA_W must be at least 1");
   end
   if (NET_STAGES != 3 || LANES != 4) begin : g_bad_net
      $error("qsort4_pipe: network is defined for four lanes in three stages");
   end

   logic                         vld_chain  [NET_STAGES+1];
   logic [LANES-1:0][DATA_W-1:0] data_chain [NET_STAGES+1];

   assign vld_chain[0]  = in_val;
   assign data_chain[0] = in_data;

   for (genvar s = 0; s < NET_STAGES; s++) begin : g_stage
      qsort_stage #(.DATA_W(DATA_W), .STAGE(s)) u_stage (
         .clk      (clk),
         .rst      (rst),
         .in_vld   (vld_chain[s]),
         .in_data  (data_chain[s]),
         .out_vld  (vld_chain[s+1]),
         .out_data (data_chain[s+1])
      );
   end

   assign out_val  = vld_chain[NET_STAGES];
   assign out_data = data_chain[NET_STAGES];
endmodule

// File: rtl/qsort4_pipe_chk.sv
module qsort4_pipe_chk
   import qsort_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         in_val,
   input logic [LANES-1:0][DATA_W-1:0] in_data,
   input logic                         out_val,
   input logic [LANES-1:0][DATA_W-1:0] out_data
);
   localparam int unsigned SUM_W = DATA_W + 2;

   logic [1:0]        warm;
   logic              rst_q;
   logic [SUM_W-1:0]  in_sum, out_sum;
   logic [DATA_W-1:0] in_xor, out_xor;

   always_ff @(posedge clk) begin
      if (rst)              warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   always_ff @(posedge clk) rst_q <= rst;

   always_comb begin
      in_sum = '0; out_sum = '0; in_xor = '0; out_xor = '0;
      for (int i = 0; i < LANES; i++) begin
         in_sum  = in_sum  + SUM_W'(in_data[i]);
         out_sum = out_sum + SUM_W'(out_data[i]);
         in_xor  = in_xor  ^ in_data[i];
         out_xor = out_xor ^ out_data[i];
      end
   end

   p_ascending_r1: assert property (@(posedge clk) disable iff (rst)
      out_val |-> (out_data[0] <= out_data[1] && out_data[1] <= out_data[2]
                   && out_data[2] <= out_data[3]));

   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (out_val == $past(in_val, 3)));

   p_content_sum_r3: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && out_val) |-> (out_sum == $past(in_sum, 3)));

   p_content_xor_r3: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && out_val) |-> (out_xor == $past(in_xor, 3)));

   p_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && $past(in_val, 3) && $past(in_val, 2)) |=> (out_val && $past(out_val)));

   always @(posedge clk) begin
      if (rst_q) begin
         p_reset_clear_r5: assert (!out_val);
      end
   end
endmodule

bind qsort4_pipe qsort4_pipe_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_val   (in_val),
   .in_data  (in_data),
   .out_val  (out_val),
   .out_data (out_data)
);

// File: tb/sim_qsort4_pipe.sv
module sim_qsort4_pipe;
   localparam int NV = 12;

   // Lane 0 in the low byte. Expected output: smallest value in the low byte.
   localparam logic [31:0] VEC_IN [NV] = '{
      32'h01030204, 32'h04030201, 32'h01020304, 32'h02080808,
      32'h01010101, 32'h09030309, 32'h7F8000FF, 32'h08020802,
      32'h01070609, 32'h09000804, 32'h00000000, 32'hFFFFFFFF };
   localparam logic [31:0] VEC_EXP [NV] = '{
      32'h04030201, 32'h04030201, 32'h04030201, 32'h08080802,
      32'h01010101, 32'h09090303, 32'hFF807F00, 32'h08080202,
      32'h09070601, 32'h09080400, 32'h00000000, 32'hFFFFFFFF };

   logic             clk = 1'b0;
   logic             rst;
   logic             in_val;
   logic [3:0][7:0]  in_data;
   logic             out_val;
   logic [3:0][7:0]  out_data;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   logic        mv [3];
   logic [31:0] md [3];

   always #5 clk = ~clk;

   qsort4_pipe #(.DATA_W(8)) u0 (
      .clk(clk), .rst(rst), .in_val(in_val), .in_data(in_data),
      .out_val(out_val), .out_data(out_data));

   function automatic logic [31:0] sw_sort(input logic [31:0] d);
      logic [7:0] e [4];
      logic [7:0] t;
      for (int i = 0; i < 4; i++) e[i] = d[8*i +: 8];
      for (int p = 0; p < 3; p++)
         for (int i = 0; i < 3 - p; i++)
            if (e[i] > e[i+1]) begin t = e[i]; e[i] = e[i+1]; e[i+1] = t; end
      return {e[3], e[2], e[1], e[0]};
   endfunction

   task automatic check_out(input string tag);
      checks++;
      if (out_val !== mv[2]) begin
         fails++;
         $display("FAIL %s out_val: actual %b expected %b", tag, out_val, mv[2]);
      end
      if (mv[2] === 1'b1) begin
         checks++;
         if (out_data !== md[2]) begin
            fails++;
            $display("FAIL %s data: actual %h expected %h", tag, out_data, md[2]);
         end
      end
   endtask

   task automatic step(input logic v, input logic [31:0] din,
                       input logic [31:0] dexp, input string tag);
      @(negedge clk);
      check_out(tag);
      mv[2] = mv[1]; md[2] = md[1];
      mv[1] = mv[0]; md[1] = md[0];
      mv[0] = v;     md[0] = dexp;
      in_val  = v;
      in_data = din;
   endtask

   task automatic clear_model();
      for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; md[i] = '0; end
   endtask

   initial begin
      rst = 1'b1; in_val = 1'b0; in_data = '0;
      clear_model();
      repeat (2) @(negedge clk);
      checks++;
      if (out_val !== 1'b0) begin
         fails++;
         $display("FAIL R5 reset state out_val: actual %b expected 0", out_val);
      end
      rst = 1'b0;

      // Table walk: back-to-back groups (R1, R3, R4, R7)
      for (int i = 0; i < NV; i++) step(1'b1, VEC_IN[i], VEC_EXP[i], "R1/R3/R4/R7 table");
      for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 32'h0, "R4 drain");

      // Idle slots with junk data interleaved with valid groups (R6)
      step(1'b1, 32'h01020304, 32'h04030201, "R6 valid");
      step(1'b0, 32'hDEADBEEF, 32'h0,        "R6 idle");
      step(1'b1, 32'h02080808, 32'h08080802, "R6 valid");
      step(1'b0, 32'h00FF00FF, 32'h0,        "R6 idle");
      step(1'b0, 32'h12345678, 32'h0,        "R6 idle");
      step(1'b1, 32'h7F8000FF, 32'hFF807F00, "R6/R7 valid");
      for (int i = 0; i < 3; i++) step(1'b0, 32'hA5A5A5A5, 32'h0, "R6 drain");

      // Random stream against a software sort (R1, R2, R3, R6)
      for (int i = 0; i < 300; i++) begin
         logic        v;
         logic [31:0] d;
         v = (($urandom % 4) != 0);
         d = $urandom;
         step(v, d, sw_sort(d), "R1/R2/R3 random");
      end
      for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 32'h0, "R2 drain");

      // Reset with groups in flight and held on the inputs (R5)
      for (int i = 0; i < 3; i++) step(1'b1, 32'h05060708, 32'h08070605, "R5 prefill");
      @(negedge clk);
      rst = 1'b1; in_val = 1'b1; in_data = 32'h11223344;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (out_val !== 1'b0) begin
            fails++;
            $display("FAIL R5 during reset out_val: actual %b expected 0", out_val);
         end
      end
      rst = 1'b0; in_val = 1'b0;
      clear_model();
      for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 32'h0, "R5 after release");
      step(1'b1, 32'h00010203, 32'h03020100, "R5 recovery");
      for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 32'h0, "R5 recovery drain");
      step(1'b0, 32'h0, 32'h0, "R5 final");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R2: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule